// File: doc/BRIEF.md
# System Control and Status Port

This block is an 8-bit I/O register that sits between the host bus and a programmable interval timer. Its low nibble is writable control: one bit enables counting on the speaker timer channel, one bit lets that channel's output reach the speaker, and two bits enable reporting of the memory parity and I/O channel check conditions. Its high nibble is read-only status: the live output levels of two timer channels and the two check flags.

Software stops the speaker channel and silences the speaker by clearing the two lowest bits. It can also wait on the timer by polling the status nibble until the speaker channel's output goes high. The speaker pin is the AND of that channel's output and the speaker enable bit. All status inputs pass through a two-flop synchronizer before they reach the read port. The error conditions themselves are produced elsewhere and arrive here as level flags.

Top module: `sysctl_port`

## Requirements
- R1: While rst_ni is low and after its release, the four control bits are 0, so rd_data_o[3:0], spk_gate_o and spk_o are all 0.
- R2: A byte written with wr_en_i high at a rising clock edge stores wr_data_i[3:0] into the control bits. The stored value appears on rd_data_o[3:0] right after that edge.
- R3: Writes have no effect on bits 7:4. rd_data_o[7:4] depends only on the synchronized status inputs and the check enables, whatever wr_data_i[7:4] holds.
- R4: spk_gate_o always equals control bit 0 (1 = speaker timer channel counts).
- R5: spk_o equals tmr2_out_i AND control bit 1. This is combinational, with no clock delay from tmr2_out_i.
- R6: rd_data_o[5] shows tmr2_out_i and rd_data_o[4] shows tmr1_out_i, each delayed by exactly two rising clock edges.
- R7: rd_data_o[7] shows par_err_i (two-edge delay) only while control bit 2 is 1. rd_data_o[6] shows io_err_i (two-edge delay) only while control bit 3 is 1. Otherwise each reads 0.
- R8: A write that clears bits 0 and 1 drives spk_gate_o and spk_o to 0 right after the write edge, even if tmr2_out_i is high.
- R9: With wr_en_i low, the control bits hold their value whatever wr_data_i carries.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Write strobe for the control byte |
| wr_data_i | input | 8 | Write data; bits 7:4 are ignored |
| rd_data_o | output | 8 | Read data: status in 7:4, control in 3:0 |
| tmr1_out_i | input | 1 | Output level of the refresh timer channel |
| tmr2_out_i | input | 1 | Output level of the speaker timer channel |
| par_err_i | input | 1 | Memory parity check flag |
| io_err_i | input | 1 | I/O channel check flag |
| spk_gate_o | output | 1 | Gate of the speaker timer channel |
| spk_o | output | 1 | Speaker drive |

## Verification
The control path has a latency of one edge: a write captured at edge N appears on rd_data_o[3:0] and spk_gate_o after N. The status nibble has a latency of two edges. The speaker pin has none with respect to tmr2_out_i, but follows the enable bit one edge after the write. The bench drives every input on a falling edge and samples on a later falling edge. For status changes it checks both the falling edge after one rising edge, where the old value must still show, and the falling edge after two, where the new value must show. The speaker pin is sampled one time unit after tmr2_out_i moves, to confirm the path has no register in it.

// File: rtl/sysctl_pkg.sv
package sysctl_pkg;
  localparam int unsigned BYTE_W = 8;
  localparam int unsigned CTL_W  = 4;
  localparam int unsigned STAT_W = BYTE_W - CTL_W;
  localparam int unsigned SYNC_STAGES = 2;

  // field order is the software-visible bit order (bit 3 .. bit 0)
  typedef struct packed {
    logic io_chk_en;
    logic par_chk_en;
    logic spk_en;
    logic tmr_gate;
  } ctl_t;

  // status vector order (bit 7 .. bit 4 of the read byte)
  localparam int unsigned ST_PAR  = 3;
  localparam int unsigned ST_IO   = 2;
  localparam int unsigned ST_TMR2 = 1;
  localparam int unsigned ST_TMR1 = 0;
endpackage

// File: rtl/sysctl_sync.sv
module sysctl_sync #(
  parameter int unsigned W      = 4,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [STAGES-1:0][W-1:0] stg_q;
  logic                     armed_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stg_q <= '0;
    end else begin
      stg_q[0] <= d_i;
      for (int s = 1; s < STAGES; s++) stg_q[s] <= stg_q[s-1];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) armed_q <= 1'b0;
    else         armed_q <= 1'b1;
  end

  assign q_o = stg_q[STAGES-1];

  // each stage moves one edge: total latency equals STAGES
  p_first_stage_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    armed_q |-> stg_q[0] == $past(d_i));

  for (genvar s = 1; s < STAGES; s++) begin : g_stage_chk
    p_chain_step_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      armed_q |-> stg_q[s] == $past(stg_q[s-1]));
  end
endmodule

// File: rtl/sysctl_ctl_reg.sv
module sysctl_ctl_reg
  import sysctl_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [CTL_W-1:0] wr_data_i,
  output ctl_t             ctl_o
);
  ctl_t ctl_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      ctl_q <= '0;
    else if (wr_en_i) ctl_q <= ctl_t'(wr_data_i);
  end

  assign ctl_o = ctl_q;

  p_store_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |=> ctl_o == $past(wr_data_i));

  p_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en_i |=> $stable(ctl_o));
endmodule

// File: rtl/sysctl_spk.sv
module sysctl_spk (
  input  logic rst_ni,
  input  logic gate_bit_i,
  input  logic en_bit_i,
  input  logic tmr2_out_i,
  output logic spk_gate_o,
  output logic spk_o
);
  assign spk_gate_o = gate_bit_i;
  assign spk_o      = tmr2_out_i & en_bit_i;

  always_comb begin
    if (rst_ni === 1'b1) begin
      a_spk_needs_tmr_r5: assert (!(spk_o === 1'b1) || tmr2_out_i === 1'b1);
    end
  end
endmodule

// File: rtl/sysctl_port.sv
module sysctl_port
  import sysctl_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [BYTE_W-1:0] wr_data_i,
  output logic [BYTE_W-1:0] rd_data_o,
  input  logic              tmr1_out_i,
  input  logic              tmr2_out_i,
  input  logic              par_err_i,
  input  logic              io_err_i,
  output logic              spk_gate_o,
  output logic              spk_o
);
  ctl_t              ctl;
  logic [STAT_W-1:0] stat_raw;
  logic [STAT_W-1:0] stat_s;
  logic [STAT_W-1:0] stat_rd;
  logic              unused_wr_hi;

  // upper write bits are read-only positions
  assign unused_wr_hi = ^wr_data_i[BYTE_W-1:CTL_W];

  sysctl_ctl_reg u_ctl (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en_i),
    .wr_data_i (wr_data_i[CTL_W-1:0]),
    .ctl_o     (ctl)
  );

  always_comb begin
    stat_raw          = '0;
    stat_raw[ST_PAR]  = par_err_i;
    stat_raw[ST_IO]   = io_err_i;
    stat_raw[ST_TMR2] = tmr2_out_i;
    stat_raw[ST_TMR1] = tmr1_out_i;
  end

  sysctl_sync #(.W(STAT_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (stat_raw),
    .q_o    (stat_s)
  );

  always_comb begin
    stat_rd          = stat_s;
    stat_rd[ST_PAR]  = stat_s[ST_PAR] & ctl.par_chk_en;
    stat_rd[ST_IO]   = stat_s[ST_IO]  & ctl.io_chk_en;
  end

  assign rd_data_o = {stat_rd, ctl};

  sysctl_spk u_spk (
    .rst_ni     (rst_ni),
    .gate_bit_i (ctl.tmr_gate),
    .en_bit_i   (ctl.spk_en),
    .tmr2_out_i (tmr2_out_i),
    .spk_gate_o (spk_gate_o),
    .spk_o      (spk_o)
  );

  p_gate_tracks_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    spk_gate_o == rd_data_o[0]);

  p_par_masked_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_data_o[2] |-> !rd_data_o[7]);

  p_io_masked_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_data_o[3] |-> !rd_data_o[6]);

  p_silenced_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_data_i[1:0] == 2'b00) |=> (!spk_gate_o && !spk_o));
endmodule

// File: tb/sysctl_port_bench.sv
module sysctl_port_bench;
  logic       clk = 1'b0;
  logic       rst_ni;
  logic       wr_en;
  logic [7:0] wr_data;
  logic [7:0] rd_data;
  logic       tmr1, tmr2, par, ioe;
  logic       gate, spk;

  int total = 0;
  int bad   = 0;
  bit done  = 0;
  logic [3:0] exp_ctl;

  always #4 clk = ~clk;

  sysctl_port u_sysctl_port (
    .clk_i(clk), .rst_ni(rst_ni), .wr_en_i(wr_en), .wr_data_i(wr_data),
    .rd_data_o(rd_data), .tmr1_out_i(tmr1), .tmr2_out_i(tmr2),
    .par_err_i(par), .io_err_i(ioe), .spk_gate_o(gate), .spk_o(spk)
  );

  task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // read byte expected from the stable (already synchronized) inputs
  function automatic logic [7:0] exp_rd(logic [3:0] c, logic p, logic i,
                                        logic t2, logic t1);
    return {p & c[2], i & c[3], t2, t1, c};
  endfunction

  task automatic wr(logic [7:0] d);
    @(negedge clk); wr_en = 1'b1; wr_data = d;
    @(negedge clk); wr_en = 1'b0; wr_data = ~d;
    exp_ctl = d[3:0];
  endtask

  task automatic t_reset;
    chk("R1 rd during reset", rd_data, 8'h00);
    chk("R1 gate/spk during reset", {6'd0, gate, spk}, 8'h00);
    @(negedge clk); rst_ni = 1'b1;
    @(negedge clk);
    chk("R1 rd after release", rd_data, 8'h00);
    exp_ctl = 4'h0;
  endtask

  task automatic t_write_readback;
    wr(8'h05);
    chk("R2 readback 5", rd_data, 8'h05);
    wr(8'h0A);
    chk("R2 readback A", rd_data, 8'h0A);
    wr(8'h03);
    chk("R4 gate follows bit0", {7'd0, gate}, 8'h01);
    wr(8'h02);
    chk("R4 gate low with bit0 clear", {7'd0, gate}, 8'h00);
  endtask

  task automatic t_ignore_hi;
    wr(8'hF0);
    chk("R3 high write ignored", rd_data, 8'h00);
    wr(8'hA6);
    chk("R3 high write ignored w/ low bits", rd_data, 8'h06);
  endtask

  task automatic t_speaker;
    wr(8'h03);
    @(negedge clk); tmr2 = 1'b1; #1;
    chk("R5 spk same cycle", {7'd0, spk}, 8'h01);
    tmr2 = 1'b0; #1;
    chk("R5 spk drops with tmr2", {7'd0, spk}, 8'h00);
    tmr2 = 1'b1;
    wr(8'h01);
    chk("R5 spk off when enable clear", {7'd0, spk}, 8'h00);
    wr(8'h03);
    chk("R5 spk on again", {7'd0, spk}, 8'h01);
  endtask

  task automatic t_silence;
    // tmr2 still high here
    wr(8'h00);
    chk("R8 gate/spk silenced", {6'd0, gate, spk}, 8'h00);
    @(negedge clk); tmr2 = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic t_status_sync;
    wr(8'h00);
    @(negedge clk); tmr2 = 1'b1; tmr1 = 1'b0;
    @(negedge clk);
    chk("R6 tmr2 not yet after one edge", rd_data, exp_rd(exp_ctl, 0, 0, 0, 0));
    @(negedge clk);
    chk("R6 tmr2 after two edges", rd_data, exp_rd(exp_ctl, 0, 0, 1, 0));
    tmr2 = 1'b0; tmr1 = 1'b1;
    @(negedge clk);
    chk("R6 tmr1 not yet after one edge", rd_data, exp_rd(exp_ctl, 0, 0, 1, 0));
    @(negedge clk);
    chk("R6 tmr1 after two edges", rd_data, exp_rd(exp_ctl, 0, 0, 0, 1));
    tmr1 = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic t_flag_mask;
    wr(8'h00);
    @(negedge clk); par = 1'b1; ioe = 1'b1;
    repeat (3) @(negedge clk);
    chk("R7 flags masked", rd_data, 8'h00);
    wr(8'h04);
    chk("R7 parity shown", rd_data, 8'h84);
    wr(8'h08);
    chk("R7 io shown", rd_data, 8'h48);
    wr(8'h0C);
    chk("R7 both shown", rd_data, 8'hCC);
    @(negedge clk); par = 1'b0;
    @(negedge clk);
    chk("R7 parity clear pending", rd_data, 8'hCC);
    @(negedge clk);
    chk("R7 parity cleared", rd_data, 8'h4C);
    ioe = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic t_hold;
    wr(8'h09);
    for (int k = 0; k < 4; k++) begin
      @(negedge clk); wr_data = 8'h16 + 8'(k);
    end
    @(negedge clk);
    chk("R9 hold without strobe", rd_data, 8'h09);
  endtask

  initial begin
    rst_ni = 1'b0; wr_en = 1'b0; wr_data = 8'h00;
    tmr1 = 1'b0; tmr2 = 1'b0; par = 1'b0; ioe = 1'b0;
    exp_ctl = 4'h0;
    repeat (3) @(negedge clk);
    t_reset();
    t_write_readback();
    t_ignore_hi();
    t_speaker();
    t_silence();
    t_status_sync();
    t_flag_mask();
    t_hold();
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule